// File: doc/BRIEF.md
# Satellite Ranging Code Generator

This block produces the 1023-chip spreading code that identifies one navigation satellite, one chip per serial output bit. It runs from a single 10.23 MHz reference clock and divides that clock by ten internally, so a new chip starts every ten reference cycles, giving a chip rate of 1.023 MHz. Two 10-bit linear feedback shift registers step once per chip. The output chip is the last stage of the first register XORed with two stages of the second register. A satellite number picks which two stages are used.

A consumer samples `codeChip` whenever `chipStb` is high and marks the start of each new code period with `epochPulse`. The satellite number is captured only at reset and at each code period boundary. A change in the middle of a period therefore never breaks the sequence that is being sent.

Top module: `gpsca_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `codeChip` is 1 and both `chipStb` and `epochPulse` are 0, because both registers hold all ones.
- R2: `chipStb` is high for exactly one reference clock in every ten. Its first pulse follows the ninth rising clock edge at which `rst` is sampled low.
- R3: `codeChip` changes only on the clock edge that ends a `chipStb` cycle (or on reset). Between strobes it holds its value.
- R4: `svSel` value k selects satellite k+1. The second-register stage pairs for satellites 1 to 32 are: (2,6) (3,7) (4,8) (5,9) (1,9) (2,10) (1,8) (2,9) (3,10) (2,3) (3,4) (5,6) (6,7) (7,8) (8,9) (9,10) (1,4) (2,5) (3,6) (4,7) (5,8) (6,9) (1,3) (4,6) (5,7) (6,8) (7,9) (8,10) (1,6) (2,7) (3,8) (4,9). For satellites 1 to 10, the first ten chips, read as octal with chip 0 as the most significant bit, are 1440, 1620, 1710, 1744, 1133, 1455, 1131, 1454, 1626 and 1504.
- R5: Chip n of a period is stage 10 of the first register XOR the selected stage pair of the second register, after n steps from all ones. The first register has feedback stages 3 and 10. The second register has feedback stages 2, 3, 6, 8, 9 and 10. Stage 1 takes the feedback and the other stages shift up by one. The sequence repeats every 1023 chips.
- R6: `epochPulse` is high only together with `chipStb`, and only during the last chip (index 1022) of each period. It occurs once every 1023 strobes.
- R7: A change of `svSel` during a period has no effect on that period. The next period uses the new satellite. A value that is present in the cycle of `epochPulse` applies from chip 0 of the next period.
- R8: A reset in the middle of a period restarts at chip 0 with the satellite present on `svSel` during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10.23 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| svSel | input | 5 | Satellite number minus one |
| codeChip | output | 1 | Current code chip |
| chipStb | output | 1 | High in the last reference cycle of each chip |
| epochPulse | output | 1 | High in the strobe cycle of chip 1022 |

## Verification
The period reload and a satellite change can fall in the same cycle. When both happen in that cycle, the new selection must govern chip 0 while the old one must still govern chip 1022. The bench provokes this by changing `svSel` on the very sample where `epochPulse` is seen high, just before the reloading edge. It judges the result by comparing the whole captured period against a model of the old satellite and the following chips against a model of the new one. A second run changes `svSel` halfway through a period. In that run the old code must continue unbroken up to the boundary.

// File: rtl/gpsca_pkg.sv
package gpsca_pkg;

  localparam int SV_W = 5;

  typedef struct packed {
    logic advance;  // step registers to the next chip
    logic reload;   // end of period: restart from all ones
  } gpscaStrobe_t;

  typedef struct packed {
    logic [3:0] tapA;
    logic [3:0] tapB;
  } gpscaTaps_t;

  // Stage pair (1-based) on the second register for each satellite
  function automatic gpscaTaps_t svTaps(input logic [SV_W-1:0] sv);
    gpscaTaps_t t;
    case (sv)
      5'd0:  t = '{4'd2, 4'd6};
      5'd1:  t = '{4'd3, 4'd7};
      5'd2:  t = '{4'd4, 4'd8};
      5'd3:  t = '{4'd5, 4'd9};
      5'd4:  t = '{4'd1, 4'd9};
      5'd5:  t = '{4'd2, 4'd10};
      5'd6:  t = '{4'd1, 4'd8};
      5'd7:  t = '{4'd2, 4'd9};
      5'd8:  t = '{4'd3, 4'd10};
      5'd9:  t = '{4'd2, 4'd3};
      5'd10: t = '{4'd3, 4'd4};
      5'd11: t = '{4'd5, 4'd6};
      5'd12: t = '{4'd6, 4'd7};
      5'd13: t = '{4'd7, 4'd8};
      5'd14: t = '{4'd8, 4'd9};
      5'd15: t = '{4'd9, 4'd10};
      5'd16: t = '{4'd1, 4'd4};
      5'd17: t = '{4'd2, 4'd5};
      5'd18: t = '{4'd3, 4'd6};
      5'd19: t = '{4'd4, 4'd7};
      5'd20: t = '{4'd5, 4'd8};
      5'd21: t = '{4'd6, 4'd9};
      5'd22: t = '{4'd1, 4'd3};
      5'd23: t = '{4'd4, 4'd6};
      5'd24: t = '{4'd5, 4'd7};
      5'd25: t = '{4'd6, 4'd8};
      5'd26: t = '{4'd7, 4'd9};
      5'd27: t = '{4'd8, 4'd10};
      5'd28: t = '{4'd1, 4'd6};
      5'd29: t = '{4'd2, 4'd7};
      5'd30: t = '{4'd3, 4'd8};
      default: t = '{4'd4, 4'd9};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/gpsca_ctrl.sv
module gpsca_ctrl
  import gpsca_pkg::*;
#(
  parameter int DIV_RATIO = 10,
  parameter int CODE_LEN  = 1023
) (
  input  logic         clk,
  input  logic         rst,
  output gpscaStrobe_t stb
);
  localparam int DIV_W = $clog2(DIV_RATIO);
  localparam int IDX_W = $clog2(CODE_LEN);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CODE_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] chipIdx;
  logic advance;
  logic reload;

  assign advance = (divCnt == DIV_LAST);
  assign reload  = advance && (chipIdx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      chipIdx <= '0;
    end else begin
      if (advance) divCnt <= '0;
      else         divCnt <= divCnt + 1'b1;
      if (reload)       chipIdx <= '0;
      else if (advance) chipIdx <= chipIdx + 1'b1;
    end
  end

  assign stb.advance = advance;
  assign stb.reload  = reload;
endmodule

// File: rtl/gpsca_dp.sv
module gpsca_dp
  import gpsca_pkg::*;
#(
  parameter int REG_LEN = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  gpscaStrobe_t    stb,
  input  logic [SV_W-1:0] svSel,
  output logic            codeChip
);
  localparam logic [REG_LEN-1:0] ONES  = '1;
  // bit i holds stage i+1; feedback masks select the tapped stages
  localparam logic [REG_LEN-1:0] G1_FB = REG_LEN'(10'b10_0000_0100);
  localparam logic [REG_LEN-1:0] G2_FB = REG_LEN'(10'b11_1010_0110);

  logic [REG_LEN-1:0] g1;
  logic [REG_LEN-1:0] g2;
  gpscaTaps_t         taps;
  logic [3:0]         idxA;
  logic [3:0]         idxB;

  always_ff @(posedge clk) begin
    if (rst || stb.reload) begin
      g1   <= ONES;
      g2   <= ONES;
      taps <= svTaps(svSel);
    end else if (stb.advance) begin
      g1 <= {g1[REG_LEN-2:0], ^(g1 & G1_FB)};
      g2 <= {g2[REG_LEN-2:0], ^(g2 & G2_FB)};
    end
  end

  assign idxA     = taps.tapA - 4'd1;
  assign idxB     = taps.tapB - 4'd1;
  assign codeChip = g1[REG_LEN-1] ^ g2[idxA] ^ g2[idxB];
endmodule

// File: rtl/gpsca_gen.sv
module gpsca_gen
  import gpsca_pkg::*;
#(
  parameter int DIV_RATIO = 10,
  parameter int CODE_LEN  = 1023,
  parameter int REG_LEN   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] svSel,
  output logic       codeChip,
  output logic       chipStb,
  output logic       epochPulse
);
  gpscaStrobe_t stb;

  gpsca_ctrl #(.DIV_RATIO(DIV_RATIO), .CODE_LEN(CODE_LEN)) ctrl_i (
    .clk(clk), .rst(rst), .stb(stb)
  );

  gpsca_dp #(.REG_LEN(REG_LEN)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .svSel(svSel), .codeChip(codeChip)
  );

  assign chipStb    = stb.advance;
  assign epochPulse = stb.reload;
endmodule

// File: rtl/gpsca_chk.sv
module gpsca_chk #(
  parameter int DIV_RATIO = 10,
  parameter int CODE_LEN  = 1023
) (
  input logic clk,
  input logic rst,
  input logic chipStb,
  input logic epochPulse,
  input logic codeChip
);
  localparam int GAP_W = $clog2(DIV_RATIO) + 1;
  localparam int CNT_W = $clog2(CODE_LEN) + 1;

  logic [GAP_W-1:0] gapCnt;
  logic [CNT_W-1:0] stbCnt;

  always_ff @(posedge clk) begin
    if (rst || chipStb) gapCnt <= '0;
    else                gapCnt <= gapCnt + 1'b1;
    if (rst || epochPulse) stbCnt <= '0;
    else if (chipStb)      stbCnt <= stbCnt + 1'b1;
  end

  p_reset_chip_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (codeChip && !chipStb && !epochPulse));

  p_stb_gap_r2: assert property (@(posedge clk) disable iff (rst)
    chipStb |-> (gapCnt == GAP_W'(DIV_RATIO - 1)));

  p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
    chipStb |=> !chipStb);

  p_chip_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(chipStb)) |-> $stable(codeChip));

  p_epoch_on_stb_r6: assert property (@(posedge clk) disable iff (rst)
    epochPulse |-> chipStb);

  p_epoch_period_r6: assert property (@(posedge clk) disable iff (rst)
    chipStb |-> (epochPulse == (stbCnt == CNT_W'(CODE_LEN - 1))));
endmodule

bind gpsca_gen gpsca_chk #(.DIV_RATIO(DIV_RATIO), .CODE_LEN(CODE_LEN)) chk_i (
  .clk(clk), .rst(rst), .chipStb(chipStb), .epochPulse(epochPulse), .codeChip(codeChip)
);

// File: tb/gpsca_gen_tb.sv
module gpsca_gen_tb_top;
  localparam int CODE = 1023;
  localparam int NVEC = 10;
  localparam int VEC_SV[NVEC]  = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9};
  localparam int VEC_OCT[NVEC] = '{'o1440, 'o1620, 'o1710, 'o1744, 'o1133,
                                   'o1455, 'o1131, 'o1454, 'o1626, 'o1504};
  localparam int TAP_A[32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,
                               1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
  localparam int TAP_B[32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,
                               4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] svSel = '0;
  logic codeChip, chipStb, epochPulse;

  int checks = 0;
  int failures = 0;
  bit refSeq[CODE];
  bit capChip[2100];
  bit capEpoch[2100];
  int holdErr = 0;
  int gapErr = 0;
  bit swapOnEpoch = 0;
  logic [4:0] swapSv = '0;

  always #10 clk = ~clk;

  gpsca_gen dut_i (
    .clk(clk), .rst(rst), .svSel(svSel),
    .codeChip(codeChip), .chipStb(chipStb), .epochPulse(epochPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finishRun();
  end

  // independent model of the two registers
  task automatic buildRef(input int sv);
    bit g1[1:10];
    bit g2[1:10];
    for (int j = 1; j <= 10; j++) begin g1[j] = 1; g2[j] = 1; end
    for (int k = 0; k < CODE; k++) begin
      bit f1, f2;
      refSeq[k] = g1[10] ^ g2[TAP_A[sv]] ^ g2[TAP_B[sv]];
      f1 = g1[3] ^ g1[10];
      f2 = g2[2] ^ g2[3] ^ g2[6] ^ g2[8] ^ g2[9] ^ g2[10];
      for (int j = 10; j >= 2; j--) begin g1[j] = g1[j-1]; g2[j] = g2[j-1]; end
      g1[1] = f1;
      g2[1] = f2;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // capture n chips at their strobe cycles, checking hold and spacing
  task automatic captureChips(input int n, input int base, input bit afterReset);
    for (int i = 0; i < n; i++) begin
      logic first;
      int cyc;
      @(negedge clk);
      first = codeChip;
      cyc = 1;
      while (!chipStb && cyc < 40) begin
        @(negedge clk);
        cyc++;
        if (codeChip !== first) holdErr++;
      end
      if (!(afterReset && i == 0) && cyc != 10) gapErr++;
      capChip[base+i]  = codeChip;
      capEpoch[base+i] = epochPulse;
      if (epochPulse && swapOnEpoch) begin
        svSel = swapSv;
        swapOnEpoch = 0;
      end
    end
  endtask

  function automatic int countMis(input int from, input int to, input int refOff);
    int m = 0;
    for (int i = from; i <= to; i++)
      if (capChip[i] != refSeq[(i - refOff) % CODE]) m++;
    return m;
  endfunction

  initial begin
    int cnt;
    int mis;
    int epErr;
    int word;

    // R1: reset state
    svSel = 5'd0;
    doReset();
    check(codeChip === 1'b1, "R1", "codeChip after reset", codeChip, 1);
    check(chipStb === 1'b0, "R1", "chipStb after reset", chipStb, 0);
    check(epochPulse === 1'b0, "R1", "epochPulse after reset", epochPulse, 0);

    // R2: first strobe after nine edges with reset low
    cnt = 0;
    while (!chipStb && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == 9, "R2", "edges to first strobe", cnt, 9);

    // R4, R8: vector table of first ten chips
    for (int v = 0; v < NVEC; v++) begin
      svSel = 5'(VEC_SV[v]);
      doReset();
      captureChips(10, 0, 1);
      word = 0;
      for (int i = 0; i < 10; i++) word = (word << 1) | int'(capChip[i]);
      check(word == VEC_OCT[v], "R4", $sformatf("first chips sv%0d", VEC_SV[v] + 1),
            word, VEC_OCT[v]);
    end

    // R5, R6: full periods for satellite 13
    svSel = 5'd12;
    doReset();
    holdErr = 0;
    gapErr = 0;
    captureChips(CODE + 7, 0, 1);
    buildRef(12);
    mis = countMis(0, CODE + 6, 0);
    check(mis == 0, "R5", "period mismatches sv13", mis, 0);
    epErr = 0;
    for (int i = 0; i < CODE + 7; i++)
      if (capEpoch[i] != ((i % CODE) == CODE - 1)) epErr++;
    check(epErr == 0, "R6", "epoch position errors", epErr, 0);
    check(holdErr == 0, "R3", "chip changes inside a chip", holdErr, 0);
    check(gapErr == 0, "R2", "strobe spacing errors", gapErr, 0);

    // R7: change in the middle of a period
    svSel = 5'd0;
    doReset();
    captureChips(500, 0, 1);
    svSel = 5'd4;
    captureChips(CODE + 10 - 500, 500, 0);
    buildRef(0);
    mis = countMis(0, CODE - 1, 0);
    check(mis == 0, "R7", "old satellite kept to boundary", mis, 0);
    buildRef(4);
    mis = countMis(CODE, CODE + 9, CODE);
    check(mis == 0, "R7", "new satellite after boundary", mis, 0);

    // R7: change in the same cycle as the epoch pulse
    svSel = 5'd20;
    doReset();
    swapSv = 5'd27;
    swapOnEpoch = 1;
    captureChips(CODE + 10, 0, 1);
    buildRef(20);
    mis = countMis(0, CODE - 1, 0);
    check(mis == 0, "R7", "period before same-cycle swap", mis, 0);
    buildRef(27);
    mis = countMis(CODE, CODE + 9, CODE);
    check(mis == 0, "R7", "chips after same-cycle swap", mis, 0);

    // R8: reset in the middle of a period picks the new satellite
    captureChips(37, 0, 0);
    svSel = 5'd31;
    doReset();
    check(codeChip === 1'b1, "R8", "chip 0 after mid reset", codeChip, 1);
    captureChips(10, 0, 1);
    word = 0;
    for (int i = 0; i < 10; i++) word = (word << 1) | int'(capChip[i]);
    check(word == 'o1712, "R8", "first chips sv32 after reset", word, 'o1712);

    finishRun();
  end
endmodule